// File: doc/BRIEF.md
# UART Frame Receiver with Parity Check

This block turns an asynchronous serial line back into data words. The line is first synchronised to the core clock. It is then observed on a 16x oversampling enable that is supplied from outside. A high-to-low transition seen while the receiver is hunting opens a candidate start bit. The candidate is accepted only if the line is still low at the middle of that bit. The remaining bits of the frame are sampled at the middle of their own bit windows.

The frame shape comes from a six-bit line-configuration value, the same value the companion transmitter uses:

- word length from 5 to 8 bits;
- parity off, odd, even, or forced to a fixed level;
- one stop bit, or the longer stop setting.

The receiver latches this value when it accepts a start bit, so a change to it in the middle of a frame has no effect on that frame.

Each received word appears on a one-cycle valid strobe. The parity, framing and break flags are valid in the same cycle. The serial line cannot be paused, so the output has no ready input and no back-pressure. The sink must take the word in the cycle where valid is high. The word output keeps its last value between strobes. The three flags are high only together with valid.

Top module: `uart_frame_rx`

## Requirements
- R1: While hunting, a line value of 0 seen on a tick after a tick that saw 1 opens a candidate start bit. If the line is 1 on the 8th tick after that, the candidate is dropped, no word is produced, and hunting resumes.
- R2: Data bits are taken least significant bit first, one per 16 ticks, near mid-bit. The word length is 5 + cfg[1:0] (00 = 5 bits, 11 = 8 bits). Output bits at and above the word length read 0.
- R3: With cfg[3] = 0 there is no parity slot: the stop bit follows the last data bit directly, and the parity-error flag is never raised.
- R4: With cfg[3] = 1 and cfg[5] = 0, cfg[4] = 1 selects even parity (data plus parity bit hold an even number of ones) and cfg[4] = 0 selects odd parity. A single inverted bit raises the parity-error flag. Two inverted data bits do not raise it.
- R5: With cfg[3] = 1 and cfg[5] = 1, the parity bit is compared against a fixed level and not against the data. That level is 1 when cfg[4] = 0 and 0 when cfg[4] = 1.
- R6: Only the first stop bit is sampled. The valid strobe comes at that sample whatever the value of cfg[2], so the word is delivered before the first stop-bit period ends.
- R7: A first stop bit sampled as 0 raises the framing-error flag.
- R8: When the data bits, the parity bit (if any) and the stop bit are all 0, the break flag is raised together with the framing-error flag.
- R9: Valid is high for exactly one cycle per word. The parity, framing and break flags are 0 in every cycle where valid is 0. After reset all outputs are 0.
- R10: The configuration is captured when a start bit is accepted. Changing cfg during the rest of the frame does not change how that frame is decoded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rx_i | input | 1 | Serial line, idle high, asynchronous to clk_i |
| tick16_i | input | 1 | Oversampling enable, one cycle high, 16 per bit time |
| line_cfg_i | input | 6 | [1:0] word length, [2] long stop, [3] parity on, [4] even / fixed-0 select, [5] fixed-level parity |
| rx_data_o | output | 8 | Received word, right aligned, held between strobes |
| rx_valid_o | output | 1 | One-cycle strobe for a new word |
| par_err_o | output | 1 | Parity mismatch for this word |
| frm_err_o | output | 1 | First stop bit was 0 |
| brk_o | output | 1 | Whole frame was 0 |

## Verification
The bench sends a short low glitch that a receiver without mid-start confirmation would take for a frame, producing a word nobody sent. It flips one data bit and then two data bits under even and odd parity. A receiver that computed parity wrongly would flag the pair or miss the single flip. It sends forced-level parity frames whose data has the "wrong" number of ones, which a receiver that still computed parity would flag. It also checks that a word arrives before the first stop-bit period ends under the long-stop setting, and that a zero frame with odd parity (parity bit 1) gives a framing error but no break. Finally it rewrites the configuration during a frame, which a receiver that did not capture the configuration would decode with the wrong length.

// File: rtl/uart_rx_pkg.sv
package uart_rx_pkg;

  localparam int unsigned WORD_MAX = 8;

  typedef enum logic [2:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_PARITY,
    ST_STOP
  } rx_state_e;

  // Bit order matches the shared line-configuration value.
  typedef struct packed {
    logic       fixed_par;
    logic       even_sel;
    logic       par_on;
    logic       long_stop;
    logic [1:0] wlen;
  } line_cfg_t;

endpackage

// File: rtl/uart_rx_sync.sv
module uart_rx_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic q_o
);
  logic [STAGES-1:0] chain_q;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= d_i;
      end
    end else begin : g_many
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) chain_q <= '1;
        else         chain_q <= {chain_q[STAGES-2:0], d_i};
      end
    end
  endgenerate

  assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/uart_rx_parity_chk.sv
module uart_rx_parity_chk
  import uart_rx_pkg::*;
(
  input  line_cfg_t cfg_i,
  input  logic      data_xor_i,
  input  logic      par_bit_i,
  output logic      mismatch_o
);
  logic expect_bit;

  always_comb begin
    if (cfg_i.fixed_par) expect_bit = ~cfg_i.even_sel;
    else if (cfg_i.even_sel) expect_bit = data_xor_i;
    else expect_bit = ~data_xor_i;
    mismatch_o = cfg_i.par_on & (expect_bit ^ par_bit_i);
  end
endmodule

// File: rtl/uart_frame_rx.sv
module uart_frame_rx
  import uart_rx_pkg::*;
#(
  parameter int unsigned OVS         = 16,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_i,
  input  logic       tick16_i,
  input  logic [5:0] line_cfg_i,
  output logic [7:0] rx_data_o,
  output logic       rx_valid_o,
  output logic       par_err_o,
  output logic       frm_err_o,
  output logic       brk_o
);
  localparam int unsigned CNT_W = $clog2(OVS);
  localparam logic [CNT_W-1:0] MID_M1  = CNT_W'(OVS / 2 - 1);
  localparam logic [CNT_W-1:0] LAST_TK = CNT_W'(OVS - 1);

  rx_state_e             state_q;
  logic [CNT_W-1:0]      tick_cnt_q;
  logic [2:0]            bit_idx_q;
  logic [WORD_MAX-1:0]   shift_q;
  logic                  xor_q;
  logic                  any_one_q;
  logic                  line_q;
  logic                  par_bit_q;
  line_cfg_t             cfg_q;
  logic                  rx_s;
  logic                  par_bad;
  logic                  slot_mid;
  logic [2:0]            last_idx;
  logic [3:0]            word_bits;

  uart_rx_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (rx_i),
    .q_o   (rx_s)
  );

  uart_rx_parity_chk i_par (
    .cfg_i     (cfg_q),
    .data_xor_i(xor_q),
    .par_bit_i (par_bit_q),
    .mismatch_o(par_bad)
  );

  assign slot_mid  = tick16_i && (tick_cnt_q == LAST_TK);
  assign last_idx  = {1'b0, cfg_q.wlen} + 3'd4;
  assign word_bits = {2'b00, cfg_q.wlen} + 4'd5;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      tick_cnt_q <= '0;
      bit_idx_q  <= '0;
      shift_q    <= '0;
      xor_q      <= 1'b0;
      any_one_q  <= 1'b0;
      line_q     <= 1'b1;
      par_bit_q  <= 1'b0;
      cfg_q      <= '0;
      rx_data_o  <= '0;
      rx_valid_o <= 1'b0;
      par_err_o  <= 1'b0;
      frm_err_o  <= 1'b0;
      brk_o      <= 1'b0;
    end else begin
      rx_valid_o <= 1'b0;
      par_err_o  <= 1'b0;
      frm_err_o  <= 1'b0;
      brk_o      <= 1'b0;
      if (tick16_i) begin
        case (state_q)
          ST_HUNT: begin
            line_q <= rx_s;
            if (line_q && !rx_s) begin
              state_q    <= ST_START;
              tick_cnt_q <= '0;
            end
          end
          ST_START: begin
            if (tick_cnt_q == MID_M1) begin
              if (!rx_s) begin
                state_q    <= ST_DATA;
                tick_cnt_q <= '0;
                bit_idx_q  <= '0;
                shift_q    <= '0;
                xor_q      <= 1'b0;
                any_one_q  <= 1'b0;
                cfg_q      <= line_cfg_t'(line_cfg_i);
              end else begin
                state_q <= ST_HUNT;
                line_q  <= 1'b1;
              end
            end else begin
              tick_cnt_q <= tick_cnt_q + 1'b1;
            end
          end
          default: begin
            tick_cnt_q <= (tick_cnt_q == LAST_TK) ? '0 : tick_cnt_q + 1'b1;
          end
        endcase
      end

      if (slot_mid) begin
        case (state_q)
          ST_DATA: begin
            shift_q[bit_idx_q] <= rx_s;
            xor_q              <= xor_q ^ rx_s;
            any_one_q          <= any_one_q | rx_s;
            if (bit_idx_q == last_idx)
              state_q <= cfg_q.par_on ? ST_PARITY : ST_STOP;
            else
              bit_idx_q <= bit_idx_q + 1'b1;
          end
          ST_PARITY: begin
            par_bit_q <= rx_s;
            any_one_q <= any_one_q | rx_s;
            state_q   <= ST_STOP;
          end
          ST_STOP: begin
            rx_valid_o <= 1'b1;
            rx_data_o  <= shift_q;
            par_err_o  <= par_bad;
            frm_err_o  <= !rx_s;
            brk_o      <= !rx_s && !any_one_q;
            line_q     <= rx_s;
            state_q    <= ST_HUNT;
          end
          default: ;
        endcase
      end
    end
  end

  AST_VALID_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |=> !rx_valid_o); // R9
  AST_FLAGS_NEED_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (par_err_o || frm_err_o || brk_o) |-> rx_valid_o); // R9
  AST_BREAK_IS_FRAMING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    brk_o |-> (frm_err_o && rx_data_o == '0)); // R8
  AST_NO_PARITY_WHEN_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_valid_o && !cfg_q.par_on) |-> !par_err_o); // R3
  AST_UPPER_BITS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_valid_o |-> ((rx_data_o >> word_bits) == '0)); // R2
  AST_START_CONFIRMED_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_START && tick16_i && tick_cnt_q == MID_M1 && rx_s) |=> state_q == ST_HUNT); // R1
endmodule

// File: tb/test_uart_frame_rx.sv
module test_uart_frame_rx;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rx = 1'b1;
  logic       tick = 1'b0;
  logic [5:0] cfg = 6'b000011;
  logic [7:0] rx_data;
  logic       rx_valid, par_err, frm_err, brk;

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int tdiv = 0;
  bit done = 1'b0;

  logic [10:0] exp_q[$];
  string       tag_q[$];

  localparam int BIT_CLK = 64;

  always #2.5 clk = ~clk;

  uart_frame_rx i_uart_frame_rx (
    .clk_i(clk), .rst_ni(rst_n), .rx_i(rx), .tick16_i(tick),
    .line_cfg_i(cfg), .rx_data_o(rx_data), .rx_valid_o(rx_valid),
    .par_err_o(par_err), .frm_err_o(frm_err), .brk_o(brk)
  );

  always @(posedge clk) begin
    tdiv <= (tdiv == 3) ? 0 : tdiv + 1;
    tick <= (tdiv == 3);
    cyc  <= cyc + 1;
  end

  task automatic chk(input bit ok, input string what, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", what, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor / scoreboard
  initial begin
    forever begin
      @(negedge clk);
      if (rx_valid) begin
        if (exp_q.size() == 0) begin
          chk(1'b0, "R1 unexpected word", {brk, frm_err, par_err, rx_data}, 0);
        end else begin
          logic [10:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(rx_data == e[7:0], {"R2 data ", t}, rx_data, e[7:0]);
          chk(par_err == e[8], {"parity ", t}, par_err, e[8]);
          chk(frm_err == e[9], {"R7 framing ", t}, frm_err, e[9]);
          chk(brk == e[10], {"R8 break ", t}, brk, e[10]);
          @(negedge clk);
          chk(!rx_valid && !par_err && !frm_err && !brk, "R9 strobe one cycle",
              {rx_valid, par_err, frm_err, brk}, 0);
        end
      end
    end
  end

  task automatic send(input logic [5:0] c, input logic [7:0] word, input logic [7:0] flip,
                      input bit pflip, input bit stop_v, input logic [5:0] c_mid,
                      input string tag);
    int n;
    logic [7:0] mask, d;
    bit p, pe, bk;
    n = 5 + c[1:0];
    mask = 8'((9'd1 << n) - 1);
    d = (word ^ flip) & mask;
    if (c[5])      p = ~c[4];
    else if (c[4]) p = ^(word & mask);
    else           p = ~^(word & mask);
    p = p ^ pflip;
    if (!c[3])     pe = 1'b0;
    else if (c[5]) pe = (p != ~c[4]);
    else if (c[4]) pe = (^d) ^ p;
    else           pe = ~((^d) ^ p);
    bk = !stop_v && (d == 0) && (!c[3] || !p);
    exp_q.push_back({bk, !stop_v, pe, d});
    tag_q.push_back(tag);
    cfg = c;
    rx = 1'b0;
    wait_clk(BIT_CLK);
    cfg = c_mid;
    for (int i = 0; i < n; i++) begin
      rx = d[i];
      wait_clk(BIT_CLK);
    end
    if (c[3]) begin
      rx = p;
      wait_clk(BIT_CLK);
    end
    rx = stop_v;
    wait_clk(BIT_CLK);
    chk(exp_q.size() == 0, {"R6 word before first stop ends ", tag}, exp_q.size(), 0);
    rx = 1'b1;
    if (c[2]) wait_clk(BIT_CLK);
    wait_clk(BIT_CLK / 2);
    cfg = c;
  endtask

  initial begin
    wait_clk(5);
    chk(rx_data == 0 && !rx_valid && !par_err && !frm_err && !brk, "R9 reset state",
        {rx_valid, par_err, frm_err, brk, rx_data}, 0);
    rst_n = 1'b1;
    wait_clk(BIT_CLK * 2);

    send(6'b000011, 8'hA5, 8'h00, 0, 1, 6'b000011, "R2 8-bit no parity R3");
    send(6'b000000, 8'hF5, 8'h00, 0, 1, 6'b000000, "R2 5-bit upper masked R3");
    send(6'b000001, 8'h3C, 8'h00, 0, 1, 6'b000001, "R2 6-bit R3");
    send(6'b011010, 8'h5A, 8'h00, 0, 1, 6'b011010, "R4 even clean");
    send(6'b011010, 8'h5A, 8'h04, 0, 1, 6'b011010, "R4 even single flip");
    send(6'b011010, 8'h5A, 8'h09, 0, 1, 6'b011010, "R4 even double flip");
    send(6'b001011, 8'h81, 8'h00, 0, 1, 6'b001011, "R4 odd clean");
    send(6'b001011, 8'h81, 8'h00, 1, 1, 6'b001011, "R4 odd parity flip");
    send(6'b001011, 8'h81, 8'h42, 0, 1, 6'b001011, "R4 odd double flip");
    send(6'b101011, 8'h01, 8'h00, 0, 1, 6'b101011, "R5 fixed one ok");
    send(6'b101011, 8'h03, 8'h00, 0, 1, 6'b101011, "R5 fixed one even data ok");
    send(6'b101011, 8'h03, 8'h00, 1, 1, 6'b101011, "R5 fixed one wrong bit");
    send(6'b111011, 8'h07, 8'h00, 0, 1, 6'b111011, "R5 fixed zero ok");
    send(6'b111011, 8'h07, 8'h00, 1, 1, 6'b111011, "R5 fixed zero wrong bit");
    send(6'b000111, 8'hC3, 8'h00, 0, 1, 6'b000111, "R6 long stop");
    send(6'b001111, 8'h96, 8'h00, 0, 1, 6'b001111, "R6 long stop parity");
    send(6'b000011, 8'h55, 8'h00, 0, 0, 6'b000011, "R7 framing only");
    send(6'b000011, 8'h00, 8'h00, 0, 0, 6'b000011, "R8 break no parity");
    send(6'b011011, 8'h00, 8'h00, 0, 0, 6'b011011, "R8 break even parity");
    send(6'b001011, 8'h00, 8'h00, 0, 0, 6'b001011, "R8 odd zero no break");

    // R1: short low glitch must not produce a word
    rx = 1'b0;
    wait_clk(16);
    rx = 1'b1;
    wait_clk(BIT_CLK * 12);
    chk(exp_q.size() == 0, "R1 glitch produced nothing pending", exp_q.size(), 0);
    send(6'b000011, 8'h6E, 8'h00, 0, 1, 6'b000011, "R1 frame after glitch");

    // R10: configuration rewritten during the frame
    send(6'b000011, 8'hB7, 8'h00, 0, 1, 6'b011000, "R10 cfg changed mid frame");
    send(6'b011001, 8'h2D, 8'h00, 0, 1, 6'b000011, "R10 parity cfg changed mid frame");

    wait_clk(BIT_CLK * 2);
    chk(exp_q.size() == 0, "R9 all words delivered", exp_q.size(), 0);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R9 act=%0d exp=%0d", cyc, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule